// File: doc/BRIEF.md
# USB Line State Monitor

This block sits between the two raw differential bus wires of a USB port and the link-layer controller. It reports the bus condition as a two-bit code: single-ended zero, J, K or single-ended one. It also marks where packets begin and end, so the controller can time inter-packet gaps and follow bus activity without decoding the data itself.

When the controller's clock is running and stable, the reported code passes through a two-flop synchroniser, so it changes only in step with that clock. When the clock cannot be relied on, for example while a suspended device is waking up, the code comes straight from the wires through combinational logic. A speed input selects which pair of transitions on the synchronised code counts as packet start and packet end. Each event is a one-cycle pulse, and a level output stays high while a packet is in flight.

Top module: `usb_line_monitor`

## Requirements
- R1: With `clk_usable` high, `line_state` equals `{dp, dm}` as sampled at the rising edge two edges earlier. The code is bit 1 = DP and bit 0 = DM: 00 is SE0, 10 is J, 01 is K and 11 is SE1.
- R2: With `clk_usable` low, `line_state` equals `{dp, dm}` in the same cycle, through combinational logic only.
- R3: In high-speed mode (`hs_mode` = 1), with no packet active, a change of the synchronised code from SE0 to J raises `pkt_start` for exactly one cycle. This is the same cycle in which the registered code first reads J, which is two edges after the wires change.
- R4: In high-speed mode, with a packet active, a change of the synchronised code from J to SE0 raises `pkt_end` for one cycle. This is the cycle in which the registered code first reads SE0.
- R5: In full-speed mode (`hs_mode` = 0), with no packet active, a change of the synchronised code from J to K raises `pkt_start` for one cycle.
- R6: In full-speed mode, with a packet active, a change of the synchronised code from SE0 to J raises `pkt_end` for one cycle.
- R7: No other transition produces an event. While a packet is active, repeated J/K toggles and SE1 or K glitches give no extra `pkt_start`. While no packet is active, an end-type transition gives no `pkt_end`.
- R8: `pkt_active` rises in the cycle after a `pkt_start` pulse. It stays high through the cycle of the matching `pkt_end` pulse and is low in the cycle after it.
- R9: While `rst` (active high, synchronous) is high, `pkt_active`, `pkt_start` and `pkt_end` are low after the next edge, and the registered code is SE0. With `clk_usable` high, `line_state` therefore reads 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_usable | input | 1 | 1: registered line state; 0: combinational line state |
| hs_mode | input | 1 | 1: high-speed event rules; 0: full-speed event rules |
| dp | input | 1 | Positive bus wire |
| dm | input | 1 | Negative bus wire |
| line_state | output | 2 | Bus condition code {DP, DM} |
| pkt_active | output | 1 | High while a packet is in flight |
| pkt_start | output | 1 | One-cycle packet start pulse |
| pkt_end | output | 1 | One-cycle packet end pulse |

## Verification
The bench aims at full-speed packets whose body toggles between J and K. A detector that is not gated by the packet-active flag would emit a second start on every J-to-K edge. It also aims at end-type transitions on an idle bus: SE0 followed by J in full speed must not create a stray end pulse that would unbalance the controller's packet count. The clock-usable switch is toggled while the wires change, so a mux tied to the wrong path would show the pins either two cycles late or unsynchronised. A reset in the middle of a packet and a high-speed K/SE1 glitch inside a packet check that the active flag clears cleanly and that glitches are not taken for packet boundaries.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_K   = 2'b01,
    LS_J   = 2'b10,
    LS_SE1 = 2'b11
  } lstate_t;

  localparam int LS_W = 2;

endpackage

// File: rtl/lsm_sync.sv
module lsm_sync #(
  parameter int              STAGES  = 2,
  parameter int              WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q = chain_q[LAST];

endmodule

// File: rtl/lsm_path_mux.sv
module lsm_path_mux
  import lsm_pkg::*;
(
  input  logic    use_reg,
  input  lstate_t reg_ls,
  input  logic    pin_p,
  input  logic    pin_n,
  output lstate_t out_ls
);

  lstate_t raw_ls;

  always_comb begin
    raw_ls = lstate_t'({pin_p, pin_n});
    out_ls = use_reg ? reg_ls : raw_ls;
  end

endmodule

// File: rtl/lsm_event.sv
module lsm_event
  import lsm_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    hs_mode,
  input  lstate_t ls_now,
  output logic    sop_pulse,
  output logic    eop_pulse,
  output logic    in_pkt
);

  lstate_t prev_q;
  logic    active_q;
  logic    sop_hit;
  logic    eop_hit;

  always_comb begin
    if (hs_mode) begin
      sop_hit = (prev_q == LS_SE0) && (ls_now == LS_J);
      eop_hit = (prev_q == LS_J)   && (ls_now == LS_SE0);
    end else begin
      sop_hit = (prev_q == LS_J)   && (ls_now == LS_K);
      eop_hit = (prev_q == LS_SE0) && (ls_now == LS_J);
    end
  end

  assign sop_pulse = sop_hit && !active_q;
  assign eop_pulse = eop_hit && active_q;
  assign in_pkt    = active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= LS_SE0;
      active_q <= 1'b0;
    end else begin
      prev_q <= ls_now;
      if (sop_pulse) begin
        active_q <= 1'b1;
      end else if (eop_pulse) begin
        active_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/usb_line_monitor.sv
module usb_line_monitor
  import lsm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clk_usable,
  input  logic       hs_mode,
  input  logic       dp,
  input  logic       dm,
  output logic [1:0] line_state,
  output logic       pkt_active,
  output logic       pkt_start,
  output logic       pkt_end
);

  logic [LS_W-1:0] synced;
  lstate_t         reg_ls;
  lstate_t         muxed_ls;

  lsm_sync #(
    .STAGES  (SYNC_STAGES),
    .WIDTH   (LS_W),
    .RST_VAL (LS_SE0)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({dp, dm}),
    .q   (synced)
  );

  assign reg_ls = lstate_t'(synced);

  lsm_path_mux u_mux (
    .use_reg (clk_usable),
    .reg_ls  (reg_ls),
    .pin_p   (dp),
    .pin_n   (dm),
    .out_ls  (muxed_ls)
  );

  lsm_event u_event (
    .clk       (clk),
    .rst       (rst),
    .hs_mode   (hs_mode),
    .ls_now    (reg_ls),
    .sop_pulse (pkt_start),
    .eop_pulse (pkt_end),
    .in_pkt    (pkt_active)
  );

  assign line_state = muxed_ls;

endmodule

// File: rtl/usb_line_monitor_chk.sv
module usb_line_monitor_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       clk_usable,
  input logic       hs_mode,
  input logic       dp,
  input logic       dm,
  input logic [1:0] line_state,
  input logic       pkt_active,
  input logic       pkt_start,
  input logic       pkt_end
);

  logic [1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst) age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  generate
    if (SYNC_STAGES == 2) begin : g_lat
      AST_REG_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (clk_usable && age_q >= 2'd2) |-> (line_state == $past({dp, dm}, 2))); // R1
    end
  endgenerate

  AST_COMB_PATH: assert property (@(posedge clk) disable iff (rst)
    !clk_usable |-> (line_state == {dp, dm})); // R2

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pkt_start |=> !pkt_start); // R3

  AST_END_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pkt_end |=> !pkt_end); // R4

  AST_NO_START_IN_PKT: assert property (@(posedge clk) disable iff (rst)
    pkt_active |-> !pkt_start); // R7

  AST_NO_END_IDLE: assert property (@(posedge clk) disable iff (rst)
    !pkt_active |-> !pkt_end); // R7

  AST_START_ARMS: assert property (@(posedge clk) disable iff (rst)
    pkt_start |=> pkt_active); // R8

  AST_END_DISARMS: assert property (@(posedge clk) disable iff (rst)
    pkt_end |=> !pkt_active); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!pkt_active && !pkt_start && !pkt_end)); // R9

  AST_MODE_KNOWN: assert property (@(posedge clk) disable iff (rst)
    (pkt_start || pkt_end) |-> !$isunknown(hs_mode)); // R5

endmodule

bind usb_line_monitor usb_line_monitor_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/usb_line_monitor_bench.sv
module usb_line_monitor_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] P_SE0 = 2'b00, P_K = 2'b01, P_J = 2'b10, P_SE1 = 2'b11;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clk_usable = 1'b1;
  logic       hs_mode = 1'b1;
  logic       dp = 1'b0;
  logic       dm = 1'b0;
  logic [1:0] line_state;
  logic       pkt_active, pkt_start, pkt_end;

  int total = 0;
  int bad = 0;
  int n_start = 0;
  int n_end = 0;

  int  mq[$];
  int  m_act = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_line_monitor u_usb_line_monitor (
    .clk(clk), .rst(rst), .clk_usable(clk_usable), .hs_mode(hs_mode),
    .dp(dp), .dm(dm), .line_state(line_state), .pkt_active(pkt_active),
    .pkt_start(pkt_start), .pkt_end(pkt_end)
  );

  function automatic bit is_sop(int prv, int cur, bit hs);
    return hs ? (prv == 0 && cur == 2) : (prv == 2 && cur == 1);
  endfunction

  function automatic bit is_eop(int prv, int cur, bit hs);
    return hs ? (prv == 2 && cur == 0) : (prv == 0 && cur == 2);
  endfunction

  // Reference: mq[0] newest sample, mq[1] reported code, mq[2] code one cycle before
  initial mq = {0, 0, 0};

  always @(posedge clk) begin
    if (rst) begin
      mq = {0, 0, 0};
      m_act = 0;
    end else begin
      if (m_act == 0 && is_sop(mq[2], mq[1], hs_mode)) m_act = 1;
      else if (m_act == 1 && is_eop(mq[2], mq[1], hs_mode)) m_act = 0;
      mq.push_front(int'({dp, dm}));
      void'(mq.pop_back());
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    int e_ls, e_s, e_e;
    e_ls = clk_usable ? mq[1] : int'({dp, dm});
    e_s  = (m_act == 0 && is_sop(mq[2], mq[1], hs_mode)) ? 1 : 0;
    e_e  = (m_act == 1 && is_eop(mq[2], mq[1], hs_mode)) ? 1 : 0;
    chk(rst ? "R9" : (clk_usable ? "R1" : "R2"), int'(line_state), e_ls);
    chk(rst ? "R9" : (hs_mode ? "R3" : "R5"), int'(pkt_start), e_s);
    chk(rst ? "R9" : (hs_mode ? "R4" : "R6"), int'(pkt_end), e_e);
    chk(rst ? "R9" : "R8", int'(pkt_active), m_act);
    if (pkt_start) n_start++;
    if (pkt_end) n_end++;
  endtask

  task automatic step(input logic r, input logic cu, input logic hs, input logic [1:0] pins, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      rst = r; clk_usable = cu; hs_mode = hs; {dp, dm} = pins;
      #1;
      if (!cu) chk("R2", int'(line_state), int'(pins));
    end
  endtask

  task automatic expect_events(string req, int s0, int e0, int ds, int de);
    chk(req, n_start - s0, ds);
    chk(req, n_end - e0, de);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s0, e0;
    // R9: reset state
    step(1, 1, 1, P_J, 3);
    @(negedge clk);
    chk("R9", int'(line_state), 0);
    chk("R9", int'(pkt_active), 0);

    // R3 R4: clean high-speed packet
    s0 = n_start; e0 = n_end;
    step(0, 1, 1, P_SE0, 4);
    step(0, 1, 1, P_J, 8);
    step(0, 1, 1, P_SE0, 5);
    expect_events("R3_R4", s0, e0, 1, 1);

    // R7: high-speed packet with K and SE1 glitches inside
    s0 = n_start; e0 = n_end;
    step(0, 1, 1, P_J, 3);
    step(0, 1, 1, P_K, 1);
    step(0, 1, 1, P_J, 2);
    step(0, 1, 1, P_SE1, 1);
    step(0, 1, 1, P_J, 2);
    step(0, 1, 1, P_SE0, 5);
    expect_events("R7", s0, e0, 1, 1);

    // R5 R6 R7: full-speed packet with J/K toggling body
    s0 = n_start; e0 = n_end;
    step(0, 1, 0, P_J, 4);
    step(0, 1, 0, P_K, 1);
    step(0, 1, 0, P_J, 1);
    step(0, 1, 0, P_K, 1);
    step(0, 1, 0, P_J, 1);
    step(0, 1, 0, P_K, 2);
    step(0, 1, 0, P_SE0, 2);
    step(0, 1, 0, P_J, 5);
    expect_events("R5_R6", s0, e0, 1, 1);

    // R7: end-type transition on idle full-speed bus
    s0 = n_start; e0 = n_end;
    step(0, 1, 0, P_SE0, 2);
    step(0, 1, 0, P_J, 4);
    expect_events("R7", s0, e0, 0, 0);

    // R2: unusable clock, combinational code
    s0 = n_start; e0 = n_end;
    step(0, 0, 0, P_J, 2);
    step(0, 0, 0, P_K, 2);
    step(0, 0, 0, P_SE1, 1);
    step(0, 0, 0, P_J, 2);
    step(0, 1, 0, P_SE0, 2);
    step(0, 1, 0, P_J, 5);
    expect_events("R2", s0, e0, 1, 1);

    // R9: reset in the middle of a high-speed packet
    step(0, 1, 1, P_SE0, 3);
    step(0, 1, 1, P_J, 4);
    chk("R8", int'(pkt_active), 1);
    step(1, 1, 1, P_J, 2);
    @(negedge clk);
    chk("R9", int'(pkt_active), 0);
    chk("R9", int'(line_state), 0);
    step(0, 1, 1, P_J, 4);
    step(0, 1, 1, P_SE0, 5);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule